// File: doc/BRIEF.md
# Real-Time Clock Core with Periodic Interrupt

This block keeps time of day in BCD seconds, minutes and hours and raises one interrupt line for three events: a periodic rate, an alarm match and the end of each one-second update. A single clock enable at 32.768 kHz drives everything. Software reaches the registers indirectly. A write on the address port loads an index, and the data port then reads or writes the byte that index selects. The time bytes sit at indices 00h to 05h, in the order second, second alarm, minute, minute alarm, hour, hour alarm. The control and status bytes sit at 0Ah to 0Dh.

A small sequencer with four states runs the divider.
- HOLD: the divider and periodic counters are cleared. It goes to IDLE once the divider select leaves its reset codes.
- IDLE: the divider counts. It goes to GUARD when the divider count enters the last `UIP_LEAD` ticks of a second and updates are not halted.
- GUARD: the update-in-progress bit is high. It goes to UPDATE on the tick that wraps the divider, or back to IDLE if software halts updates.
- UPDATE: lasts one clock. The time bytes advance, the update and alarm flags are set, and the sequencer returns to IDLE.

Any state goes to HOLD when a reset code is written.

Top module: `rtc_core`

## Requirements
- R1: After reset, index 0Ah reads 60h, 0Bh reads 00h, 0Ch reads 00h, 0Dh reads 80h, the time and alarm bytes read 00h, and `irq` is 0.
- R2: Each update advances seconds 00 to 59 in BCD. A carry advances minutes 00 to 59, which carry into hours 00 to 23. 23:59:59 becomes 00:00:00.
- R3: Bit 7 of index 0Ah is the update-in-progress bit. With `tick_en` held high and the divider released at clock edge 0, it reads 0 through edge 2^DIV_W−UIP_LEAD and 1 from edge 2^DIV_W−UIP_LEAD+1 through edge 2^DIV_W. It reads 0 again after edge 2^DIV_W+1, and by then the seconds byte has advanced by one.
- R4: Bits 6:4 of index 0Ah select the divider. 010 counts. 110 and 111 clear the divider and periodic counters and hold them. Any other value freezes both counters without clearing them.
- R5: Bit 7 of index 0Bh halts updates. While it is set, the time bytes do not advance, the update-in-progress bit stays 0 and no update flag is raised. Clearing it resumes updates.
- R6: Bits 3:0 of index 0Ah select the periodic rate. Code 0 gives no periodic event. Code 1 gives one every 2^7 ticks, code 2 every 2^8 ticks, and codes 3 to 15 every 2^(code−1) ticks. After the divider is released, the first event comes on tick 2^e.
- R7: Index 0Ch bits 6, 5 and 4 are the periodic, alarm and update flags. Each is set by its event whatever the enables. Bit 7 is the OR of each flag ANDed with its enable in index 0Bh bits 6, 5 and 4, and `irq` equals bit 7.
- R8: A data-port read of index 0Ch returns the flags and then clears all of them, so `irq` falls. An event in the same cycle as the read is kept.
- R9: The alarm flag is set by an update whose new time matches each alarm byte. An alarm byte with bits 7:6 equal to 11 matches any value.
- R10: Index 0Dh always reads 80h. Writes to 0Ch and 0Dh have no effect, and 0Ch bits 3:0 and 0Bh bits 3:0 read 0.
- R11: An `addr_wr` loads the index from `wdata`. Indices outside 00h–05h and 0Ah–0Dh read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz clock enable, one clock wide |
| addr_wr | input | 1 | Load the register index from `wdata` |
| data_wr | input | 1 | Write `wdata` to the indexed register |
| data_rd | input | 1 | Read strobe; reading index 0Ch clears the flags |
| wdata | input | 8 | Write data for both ports |
| rdata | output | 8 | Contents of the indexed register |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
The periodic rate is tried with codes 3, 1 and 0. These three separate the exponent mapping of the low codes from the mapping of the upper codes, and both from the disabled case. Each interval is timed to the exact clock after the divider is released. One update second is sampled on both sides of every update-in-progress edge, which separates an early or late guard window from a late time step. A 23:59:59 start with a don't-care minute alarm exercises the full carry chain and wildcard matching in the same update. Halting updates, freezing the divider with a test code, and reading the flag byte twice separate a missing gate from a missing clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_IDLE,
        ST_GUARD,
        ST_UPDATE
    } rtc_state_e;

    localparam logic [7:0] IDX_SEC   = 8'h00;
    localparam logic [7:0] IDX_ASEC  = 8'h01;
    localparam logic [7:0] IDX_MIN   = 8'h02;
    localparam logic [7:0] IDX_AMIN  = 8'h03;
    localparam logic [7:0] IDX_HR    = 8'h04;
    localparam logic [7:0] IDX_AHR   = 8'h05;
    localparam logic [7:0] IDX_CTLA  = 8'h0A;
    localparam logic [7:0] IDX_CTLB  = 8'h0B;
    localparam logic [7:0] IDX_FLAG  = 8'h0C;
    localparam logic [7:0] IDX_PWR   = 8'h0D;

    localparam logic [2:0] DIV_RUN   = 3'b010;

    // exponent of the periodic interval, in ticks
    function automatic int per_exp(input logic [3:0] code);
        if (code == 4'd1)      return 7;
        else if (code == 4'd2) return 8;
        else                   return int'(code) - 1;
    endfunction

    // BCD increment with a wrap limit; returns {carry, value}
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] lim);
        if (v >= lim)            return {1'b1, 8'h00};
        else if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
        else                     return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic alarm_eq(input logic [7:0] alm, input logic [7:0] t);
        return (alm[7:6] == 2'b11) || (alm == t);
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider
    import rtc_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int UIP_LEAD = 8,
    parameter int PER_W    = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] div_sel,
    input  logic [3:0] rate,
    input  logic       halt,
    output logic       uip,
    output logic       upd_stb,
    output logic       per_evt
);

    localparam logic [DIV_W-1:0] GUARD_START = DIV_W'((1 << DIV_W) - UIP_LEAD);
    localparam logic [DIV_W-1:0] CNT_LAST    = '1;

    rtc_state_e        state, nxt;
    logic [DIV_W-1:0]  cnt;
    logic [PER_W-1:0]  pc;
    logic [PER_W-1:0]  per_mask;
    logic              hold, run, wrap;

    assign hold = (div_sel[2:1] == 2'b11);
    assign run  = (div_sel == DIV_RUN);
    assign wrap = run && tick_en && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
            pc  <= '0;
        end else if (run && tick_en) begin
            cnt <= cnt + 1'b1;
            pc  <= pc + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:   if (!hold) nxt = ST_IDLE;
            ST_IDLE: begin
                if (hold)                                   nxt = ST_HOLD;
                else if (!halt && run && cnt >= GUARD_START) nxt = ST_GUARD;
            end
            ST_GUARD: begin
                if (hold)      nxt = ST_HOLD;
                else if (halt) nxt = ST_IDLE;
                else if (wrap) nxt = ST_UPDATE;
            end
            ST_UPDATE: nxt = hold ? ST_HOLD : ST_IDLE;
            default:   nxt = ST_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        per_mask = (PER_W'(1) << per_exp(rate)) - PER_W'(1);
        per_evt  = run && tick_en && (rate != 4'd0) && ((pc & per_mask) == per_mask);
        uip      = 1'b0;
        upd_stb  = 1'b0;
        unique case (state)
            ST_HOLD:   ;
            ST_IDLE:   ;
            ST_GUARD:  uip = 1'b1;
            ST_UPDATE: begin
                uip     = 1'b1;
                upd_stb = 1'b1;
            end
            default:   ;
        endcase
    end

    AST_UPDATE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |=> (state != ST_UPDATE)); // R3
    AST_UIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |-> (cnt >= GUARD_START)); // R3
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0) && (pc == '0) && !uip); // R4

endmodule

// File: rtl/rtc_time.sv
module rtc_time
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wdata,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hr_q,
    output logic [7:0] asec_q,
    output logic [7:0] amin_q,
    output logic [7:0] ahr_q,
    output logic       alarm_hit
);

    logic [8:0] s_nx, m_nx, h_nx;
    logic [7:0] sec_n, min_n, hr_n;

    always_comb begin
        s_nx  = bcd_step(sec_q, 8'h59);
        m_nx  = bcd_step(min_q, 8'h59);
        h_nx  = bcd_step(hr_q, 8'h23);
        sec_n = s_nx[7:0];
        min_n = s_nx[8] ? m_nx[7:0] : min_q;
        hr_n  = (s_nx[8] && m_nx[8]) ? h_nx[7:0] : hr_q;
        alarm_hit = alarm_eq(asec_q, sec_n) && alarm_eq(amin_q, min_n)
                 && alarm_eq(ahr_q, hr_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hr_q   <= '0;
            asec_q <= '0;
            amin_q <= '0;
            ahr_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                3'd0:    sec_q  <= wdata;
                3'd1:    asec_q <= wdata;
                3'd2:    min_q  <= wdata;
                3'd3:    amin_q <= wdata;
                3'd4:    hr_q   <= wdata;
                3'd5:    ahr_q  <= wdata;
                default: ;
            endcase
        end else if (upd) begin
            sec_q <= sec_n;
            min_q <= min_n;
            hr_q  <= hr_n;
        end
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && sec_q == 8'h59) |=> (sec_q == 8'h00)); // R2
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !wr_en && sec_q == 8'h59 && min_q == 8'h59 && hr_q == 8'h23)
        |=> (hr_q == 8'h00) && (min_q == 8'h00)); // R2

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_W    = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       addr_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);

    localparam int PER_W   = 15;
    localparam int N_FLAGS = 3;

    logic [7:0]         idx;
    logic [6:0]         ctl_a;
    logic [3:0]         ctl_b;
    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] flag_set;
    logic               uip, upd_stb, per_evt, alarm_hit;
    logic               rd_flags, time_we;
    logic [7:0]         sec_q, min_q, hr_q, asec_q, amin_q, ahr_q;

    assign rd_flags = data_rd && (idx == IDX_FLAG);
    assign time_we  = data_wr && (idx <= IDX_AHR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            ctl_a <= 7'h60;
            ctl_b <= '0;
        end else begin
            if (addr_wr) idx <= wdata;
            if (data_wr && idx == IDX_CTLA) ctl_a <= wdata[6:0];
            if (data_wr && idx == IDX_CTLB) ctl_b <= wdata[7:4];
        end
    end

    rtc_divider #(
        .DIV_W    (DIV_W),
        .UIP_LEAD (UIP_LEAD),
        .PER_W    (PER_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .div_sel (ctl_a[6:4]),
        .rate    (ctl_a[3:0]),
        .halt    (ctl_b[3]),
        .uip     (uip),
        .upd_stb (upd_stb),
        .per_evt (per_evt)
    );

    rtc_time u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd_stb),
        .wr_en     (time_we),
        .wr_sel    (idx[2:0]),
        .wdata     (wdata),
        .sec_q     (sec_q),
        .min_q     (min_q),
        .hr_q      (hr_q),
        .asec_q    (asec_q),
        .amin_q    (amin_q),
        .ahr_q     (ahr_q),
        .alarm_hit (alarm_hit)
    );

    // flag order: [2] periodic, [1] alarm, [0] update-ended
    assign flag_set = {per_evt, upd_stb && alarm_hit, upd_stb};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           flags[g] <= 1'b0;
            else if (flag_set[g]) flags[g] <= 1'b1;
            else if (rd_flags)    flags[g] <= 1'b0;
        end
    end

    assign irq = |(flags & ctl_b[2:0]);

    always_comb begin
        unique case (idx)
            IDX_SEC:  rdata = sec_q;
            IDX_ASEC: rdata = asec_q;
            IDX_MIN:  rdata = min_q;
            IDX_AMIN: rdata = amin_q;
            IDX_HR:   rdata = hr_q;
            IDX_AHR:  rdata = ahr_q;
            IDX_CTLA: rdata = {uip, ctl_a};
            IDX_CTLB: rdata = {ctl_b, 4'h0};
            IDX_FLAG: rdata = {irq, flags, 4'h0};
            IDX_PWR:  rdata = 8'h80;
            default:  rdata = 8'h00;
        endcase
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !per_evt && !upd_stb) |=> !irq); // R8
    AST_PF_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> ($past(ctl_a[3:0]) != 4'd0)); // R6
    AST_HALT_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_b[3] && $past(ctl_b[3])) |-> !uip); // R5

endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int UIP_LEAD   = 4;
    localparam int SEC_T      = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       addr_wr = 1'b0;
    logic       data_wr = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] q_exp[$];
    logic [7:0] q_mask[$];
    string      q_tag[$];

    rtc_core #(.DIV_W(DIV_W), .UIP_LEAD(UIP_LEAD)) u_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr_wr(addr_wr),
        .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each read strobe against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (data_rd) begin
                n_checks++;
                if (q_exp.size() == 0) begin
                    n_errors++;
                    $display("FAIL unexpected read actual %02h expected none", rdata);
                end else begin
                    logic [7:0] e, m;
                    string t;
                    e = q_exp.pop_front();
                    m = q_mask.pop_front();
                    t = q_tag.pop_front();
                    if ((rdata & m) != e) begin
                        n_errors++;
                        $display("FAIL %s actual %02h expected %02h (mask %02h)", t, rdata & m, e, m);
                    end
                end
            end
        end
    end

    task automatic set_idx(input logic [7:0] i);
        @(negedge clk); addr_wr = 1'b1; wdata = i;
        @(posedge clk); #1 addr_wr = 1'b0;
    endtask

    task automatic wr_c(input logic [7:0] i, input logic [7:0] v, output int c0);
        set_idx(i);
        @(negedge clk); data_wr = 1'b1; wdata = v;
        @(posedge clk); #1 data_wr = 1'b0; c0 = cyc;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] v);
        int c;
        wr_c(i, v, c);
    endtask

    task automatic rd_at(input int target, input logic [7:0] m, input logic [7:0] e, input string tag);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
        q_exp.push_back(e & m); q_mask.push_back(m); q_tag.push_back(tag);
        data_rd = 1'b1;
        @(posedge clk); #1 data_rd = 1'b0;
    endtask

    task automatic rd(input logic [7:0] m, input logic [7:0] e, input string tag);
        rd_at(0, m, e, tag);
    endtask

    task automatic rd_idx(input logic [7:0] i, input logic [7:0] m, input logic [7:0] e, input string tag);
        set_idx(i);
        rd(m, e, tag);
    endtask

    task automatic irq_at(input int target, input logic e, input string tag);
        @(negedge clk);
        while (cyc < target) @(negedge clk);
        n_checks++;
        if (irq !== e) begin
            n_errors++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    task automatic wait_irq(input int max, input string tag);
        int k = 0;
        @(negedge clk);
        while (!irq && k < max) begin @(negedge clk); k++; end
        n_checks++;
        if (!irq) begin
            n_errors++;
            $display("FAIL %s irq actual 0 expected 1 within %0d cycles", tag, max);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        irq_at(0, 1'b0, "R1 irq after reset");
        rd_idx(8'h0A, 8'hFF, 8'h60, "R1 ctl A reset");
        rd_idx(8'h0B, 8'hFF, 8'h00, "R1 ctl B reset");
        rd_idx(8'h0C, 8'hFF, 8'h00, "R1 flags reset");
        rd_idx(8'h00, 8'hFF, 8'h00, "R1 seconds reset");
        rd_idx(8'h05, 8'hFF, 8'h00, "R1 hour alarm reset");
        // R10 read-only bytes, R11 unused index
        wr(8'h0C, 8'hFF);
        rd(8'hFF, 8'h00, "R10 flags ignore write");
        wr(8'h0D, 8'h00);
        rd(8'hFF, 8'h80, "R10 power byte");
        wr(8'h07, 8'h55);
        rd(8'hFF, 8'h00, "R11 unused index");
        wr(8'h0B, 8'h4F);
        rd(8'hFF, 8'h40, "R10 ctl B low bits");

        // R6 code 3: every 4 ticks
        wr_c(8'h0A, 8'h23, c0);
        irq_at(c0 + 3, 1'b0, "R6 code3 before");
        irq_at(c0 + 4, 1'b1, "R6 code3 at 4");
        rd_idx(8'h0C, 8'hF0, 8'hC0, "R7 periodic flag and irq");
        wr(8'h0A, 8'h60);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");
        irq_at(0, 1'b0, "R8 irq after read in hold");

        // R6 code 1: every 128 ticks
        wr_c(8'h0A, 8'h21, c0);
        irq_at(c0 + 127, 1'b0, "R6 code1 before");
        irq_at(c0 + 128, 1'b1, "R6 code1 at 128");
        wr(8'h0A, 8'h60);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");

        // R6 code 0: disabled
        wr_c(8'h0A, 8'h20, c0);
        irq_at(c0 + 200, 1'b0, "R6 code0 irq");
        rd_idx(8'h0C, 8'h40, 8'h00, "R6 code0 no flag");

        // R3 update window, R2 single step, R7 flag without enable
        wr(8'h0A, 8'h60);
        wr(8'h0B, 8'h00);
        wr(8'h00, 8'h00);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");
        wr_c(8'h0A, 8'h20, c0);
        rd_at(c0 + SEC_T - UIP_LEAD,     8'h80, 8'h00, "R3 before window");
        rd_at(c0 + SEC_T - UIP_LEAD + 1, 8'h80, 8'h80, "R3 window start");
        rd_at(c0 + SEC_T,                8'h80, 8'h80, "R3 window end");
        rd_at(c0 + SEC_T + 1,            8'h80, 8'h00, "R3 window over");
        rd_idx(8'h00, 8'hFF, 8'h01, "R2 seconds step");
        rd_idx(8'h0C, 8'hF0, 8'h10, "R7 update flag, no irq");
        rd(8'hF0, 8'h00, "R8 second read cleared");

        // R2 full rollover, R9 wildcard alarm
        wr(8'h0A, 8'h60);
        wr(8'h00, 8'h59);
        wr(8'h02, 8'h59);
        wr(8'h04, 8'h23);
        wr(8'h01, 8'h00);
        wr(8'h03, 8'hC0);
        wr(8'h05, 8'h00);
        wr(8'h0B, 8'h30);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");
        wr_c(8'h0A, 8'h20, c0);
        irq_at(c0 + SEC_T, 1'b0, "R7 irq before update");
        irq_at(c0 + SEC_T + 1, 1'b1, "R7 irq at update");
        rd_idx(8'h0C, 8'hF0, 8'hB0, "R9 alarm and update flags");
        irq_at(0, 1'b0, "R8 irq cleared by read");
        rd_idx(8'h00, 8'hFF, 8'h00, "R2 seconds wrap");
        rd_idx(8'h02, 8'hFF, 8'h00, "R2 minutes wrap");
        rd_idx(8'h04, 8'hFF, 8'h00, "R2 hours wrap");

        // R9 no match on next second
        wait_irq(SEC_T + 20, "R7 update irq");
        rd_idx(8'h0C, 8'h20, 8'h00, "R9 no alarm on mismatch");

        // R5 halt
        wr(8'h0B, 8'h90);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");
        wr(8'h00, 8'h30);
        repeat (2 * SEC_T + 50) @(negedge clk);
        irq_at(0, 1'b0, "R5 no irq while halted");
        rd_idx(8'h0A, 8'h80, 8'h00, "R5 uip low while halted");
        rd_idx(8'h00, 8'hFF, 8'h30, "R5 seconds held");
        rd_idx(8'h0C, 8'h10, 8'h00, "R5 no update flag");
        wr(8'h0B, 8'h10);
        wait_irq(SEC_T + 20, "R5 resume");
        rd_idx(8'h00, 8'hFF, 8'h31, "R5 seconds resume");
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");

        // R4 freeze with a non-run code keeps the count
        wr(8'h0A, 8'h00);
        rd_idx(8'h0C, 8'h00, 8'h00, "clear");
        wr(8'h00, 8'h42);
        repeat (2 * SEC_T + 50) @(negedge clk);
        rd_idx(8'h00, 8'hFF, 8'h42, "R4 frozen seconds");
        rd_idx(8'h0C, 8'h10, 8'h00, "R4 no update when frozen");
        wr(8'h0A, 8'h20);
        wait_irq(SEC_T + 20, "R4 resume");
        rd_idx(8'h00, 8'hFF, 8'h43, "R4 seconds after resume");

        repeat (2) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard actual %0d pending expected 0", q_exp.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule